// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block turns one fast time-unit clock into eight slower clock outputs, grouped as four sections of two outputs. A base-period counter divides every nominal output period into N time units. N is picked by a three-level frequency select: 44 for LOW, 26 for MID and 16 for HIGH. A 0-skew output is high for the first N/2 time units of each period.

Each section has a pair of three-level function selects. The pair chooses one of nine functions. For sections 1 and 2 this is a phase skew in steps of one time unit. For sections 3 and 4 the step is two time units. The two extreme combinations of sections 3 and 4 switch the section to a divided clock, or to an inverted copy of the nominal clock. A negative skew moves the output earlier than the 0-skew reference.

Select changes are taken up only at a base-period boundary, so the outputs never produce a shortened period. Each three-level input is a 2-bit code.

Top module: `skew_clock_matrix`

## Requirements
- R1: Both outputs of a section (`clk_out_a[s]` and `clk_out_b[s]`) carry identical values on every cycle.
- R2: The base period lasts N fast-clock cycles: 44 for frequency select 00, 26 for 01 or 11, and 16 for 10. Outputs are registered, so the value seen after an edge reflects the phase count held before that edge.
- R3: Three-level codes are 00 = LOW, 01 = MID and 10 = HIGH. Code 11 on any select, including the frequency select, behaves exactly as MID.
- R4: For sections 1 and 2 (indices 0 and 1), let c = 3·rank(high select) + rank(low select), with ranks LOW=0, MID=1, HIGH=2, and let k = c − 4. The output is high while (p − k) mod N < N/2, where p is the phase count.
- R5: For sections 3 and 4 (indices 2 and 3), each c from 1 to 7 gives a skew of k = 2·(c − 4) under the same rule as R4.
- R6: For sections 3 and 4, c = 0 gives the nominal clock divided by 2. The output is high for all of every even-numbered base period counted from reset, and low for the odd ones.
- R7: For section 3, c = 8 gives the nominal clock divided by 4. The output is high during base periods 0 and 1 modulo 4, and low during 2 and 3.
- R8: For section 4, c = 8 gives the inverted nominal clock. The output is high while p ≥ N/2.
- R9: A change to the frequency select or to any function select has no effect on the outputs until the current base period ends. The new setting applies from phase 0 of the following period.
- R10: A synchronous reset drives every output low while it is asserted, clears the phase and divide counters, and loads the select inputs. The first edge after release shows phase 0 of period 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast time-unit clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 2 | Three-level frequency select choosing N |
| sel_hi | input | 8 | High-order function select, 2 bits per section, section s at bits [2s+1:2s] |
| sel_lo | input | 8 | Low-order function select, same packing as sel_hi |
| clk_out_a | output | 4 | First output of each section |
| clk_out_b | output | 4 | Second output of each section |

## Verification
A wrong phase count or a wrong latched N moves the edges of every output. The error shows on the first cycle whose position within the period differs from the bench's own count. A wrong divide counter shows only on the divided outputs, at the next base-period boundary. A select taken up mid-period shows the new skew or period before the boundary, within one period of the change. The bench follows each section cycle by cycle against its own period model, so any such slip is reported within a few base periods.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_LOW  = 2'b00;
  localparam lvl_t LVL_MID  = 2'b01;
  localparam lvl_t LVL_HIGH = 2'b10;

  typedef enum logic [1:0] {
    SK_FINE,
    SK_DIV4,
    SK_INV
  } sec_kind_t;

  // Rank of a three-level code; the spare code 11 ranks as MID.
  function automatic int lvl_rank(lvl_t v);
    case (v)
      LVL_LOW:  return 0;
      LVL_HIGH: return 2;
      default:  return 1;
    endcase
  endfunction

  // Combination index 0..8 of a select pair.
  function automatic int combo_of(lvl_t hi, lvl_t lo);
    return 3 * lvl_rank(hi) + lvl_rank(lo);
  endfunction

  // Tap with skew k: high while (cnt - k) mod n is in the first half-period.
  function automatic logic tap_high(int cnt, int k, int n);
    int t;
    t = cnt - k;
    if (t < 0) t = t + n;
    else if (t >= n) t = t - n;
    return (t < (n / 2)) ? 1'b1 : 1'b0;
  endfunction

  // Time units per base period for a frequency-select code.
  function automatic int base_count(lvl_t fs, int n_lo, int n_mid, int n_hi);
    case (lvl_rank(fs))
      0:       return n_lo;
      2:       return n_hi;
      default: return n_mid;
    endcase
  endfunction

endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
  parameter int N_LO  = 44,
  parameter int N_MID = 26,
  parameter int N_HI  = 16,
  parameter int NW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    freq_sel,
  output logic [NW-1:0] phase_cnt,
  output logic [NW-1:0] n_active,
  output logic [1:0]    div_cnt,
  output logic          wrap
);
  import skew_pkg::*;

  logic [NW-1:0] n_next;

  assign n_next = NW'(base_count(freq_sel, N_LO, N_MID, N_HI));
  assign wrap   = (phase_cnt == (n_active - NW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_cnt <= '0;
      div_cnt   <= '0;
      n_active  <= n_next;
    end else if (wrap) begin
      phase_cnt <= '0;
      div_cnt   <= div_cnt + 2'd1;
      n_active  <= n_next;
    end else begin
      phase_cnt <= phase_cnt + NW'(1);
    end
  end

endmodule

// File: rtl/skew_section.sv
module skew_section #(
  parameter skew_pkg::sec_kind_t KIND = skew_pkg::SK_FINE,
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    sel_hi,
  input  logic [1:0]    sel_lo,
  input  logic [NW-1:0] phase_cnt,
  input  logic [NW-1:0] n_active,
  input  logic [1:0]    div_cnt,
  output logic          out_a,
  output logic          out_b
);
  import skew_pkg::*;

  lvl_t hi_q, lo_q;
  int   code, cnt_i, n_i;
  logic nxt;

  assign code  = combo_of(hi_q, lo_q);
  assign cnt_i = int'(phase_cnt);
  assign n_i   = int'(n_active);

  always_ff @(posedge clk) begin
    if (load) begin
      hi_q <= sel_hi;
      lo_q <= sel_lo;
    end
  end

  always_comb begin
    if (KIND == SK_FINE) begin
      nxt = tap_high(cnt_i, code - 4, n_i);
    end else if (code == 0) begin
      nxt = ~div_cnt[0];
    end else if (code == 8) begin
      nxt = (KIND == SK_DIV4) ? ~div_cnt[1] : ~tap_high(cnt_i, 0, n_i);
    end else begin
      nxt = tap_high(cnt_i, 2 * (code - 4), n_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      out_a <= nxt;
      out_b <= nxt;
    end
  end

endmodule

// File: rtl/skew_clock_matrix.sv
module skew_clock_matrix #(
  parameter int N_LO  = 44,
  parameter int N_MID = 26,
  parameter int N_HI  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] freq_sel,
  input  logic [7:0] sel_hi,
  input  logic [7:0] sel_lo,
  output logic [3:0] clk_out_a,
  output logic [3:0] clk_out_b
);
  import skew_pkg::*;

  localparam int NSEC = 4;
  localparam int NMAX = (N_LO > N_MID) ? ((N_LO > N_HI) ? N_LO : N_HI)
                                       : ((N_MID > N_HI) ? N_MID : N_HI);
  localparam int NW   = $clog2(NMAX + 1);

  logic [NW-1:0] phase_cnt;
  logic [NW-1:0] n_active;
  logic [1:0]    div_cnt;
  logic          wrap;
  logic          load;

  assign load = rst | wrap;

  skew_phase_gen #(
    .N_LO(N_LO), .N_MID(N_MID), .N_HI(N_HI), .NW(NW)
  ) phase_i (
    .clk(clk), .rst(rst), .freq_sel(freq_sel),
    .phase_cnt(phase_cnt), .n_active(n_active),
    .div_cnt(div_cnt), .wrap(wrap)
  );

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    localparam sec_kind_t K = (s < 2) ? SK_FINE : ((s == 2) ? SK_DIV4 : SK_INV);
    skew_section #(.KIND(K), .NW(NW)) sec_i (
      .clk(clk), .rst(rst), .load(load),
      .sel_hi(sel_hi[2*s +: 2]), .sel_lo(sel_lo[2*s +: 2]),
      .phase_cnt(phase_cnt), .n_active(n_active), .div_cnt(div_cnt),
      .out_a(clk_out_a[s]), .out_b(clk_out_b[s])
    );
  end

endmodule

// File: rtl/skew_clock_matrix_chk.sv
module skew_clock_matrix_chk #(
  parameter int N_LO  = 44,
  parameter int N_MID = 26,
  parameter int N_HI  = 16,
  parameter int NW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] phase_cnt,
  input logic [NW-1:0] n_active,
  input logic [1:0]    div_cnt,
  input logic          wrap,
  input logic [3:0]    clk_out_a,
  input logic [3:0]    clk_out_b
);

  assert_pair_match_R1: assert property (@(posedge clk) disable iff (rst)
    clk_out_a == clk_out_b);

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    phase_cnt < n_active);

  assert_n_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (int'(n_active) == N_LO) || (int'(n_active) == N_MID) || (int'(n_active) == N_HI));

  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase_cnt == '0));

  assert_n_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(n_active));

  assert_div_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(div_cnt));

  assert_reset_low_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (clk_out_a == 4'b0) && (clk_out_b == 4'b0));

endmodule

bind skew_clock_matrix skew_clock_matrix_chk #(
  .N_LO(N_LO), .N_MID(N_MID), .N_HI(N_HI), .NW(NW)
) chk_i (
  .clk(clk), .rst(rst), .phase_cnt(phase_cnt), .n_active(n_active),
  .div_cnt(div_cnt), .wrap(wrap), .clk_out_a(clk_out_a), .clk_out_b(clk_out_b)
);

// File: tb/skew_clock_matrix_tb.sv
module skew_clock_matrix_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {freq_sel[18:17], use_code_11[16], c3[15:12], c2[11:8], c1[7:4], c0[3:0]}
  localparam logic [18:0] VECS [NVEC] = '{
    {2'b00, 1'b0, 4'd4, 4'd4, 4'd4, 4'd4},
    {2'b00, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0},
    {2'b00, 1'b0, 4'd8, 4'd8, 4'd8, 4'd8},
    {2'b01, 1'b0, 4'd1, 4'd2, 4'd3, 4'd5},
    {2'b01, 1'b0, 4'd6, 4'd7, 4'd1, 4'd2},
    {2'b10, 1'b0, 4'd3, 4'd5, 4'd6, 4'd7},
    {2'b10, 1'b0, 4'd8, 4'd0, 4'd8, 4'd0},
    {2'b10, 1'b0, 4'd2, 4'd7, 4'd3, 4'd1},
    {2'b01, 1'b1, 4'd7, 4'd6, 4'd5, 4'd4},
    {2'b11, 1'b0, 4'd4, 4'd3, 4'd2, 4'd1},
    {2'b00, 1'b0, 4'd5, 4'd6, 4'd7, 4'd8},
    {2'b10, 1'b0, 4'd1, 4'd1, 4'd0, 4'd8}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] freq_sel;
  logic [7:0] sel_hi, sel_lo;
  logic [3:0] clk_out_a, clk_out_b;

  int checks = 0;
  int fails  = 0;
  int m_p, m_d, m_n;
  logic [1:0] a_fs;
  logic [7:0] a_hi, a_lo;
  int mis [4];
  int pmis;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_clock_matrix dut_i (
    .clk(clk), .rst(rst), .freq_sel(freq_sel),
    .sel_hi(sel_hi), .sel_lo(sel_lo),
    .clk_out_a(clk_out_a), .clk_out_b(clk_out_b)
  );

  function automatic int n_of(logic [1:0] f);
    if (f == 2'b00) return 44;
    if (f == 2'b10) return 16;
    return 26;
  endfunction

  function automatic int rank(logic [1:0] v);
    if (v == 2'b00) return 0;
    if (v == 2'b10) return 2;
    return 1;
  endfunction

  function automatic logic [1:0] code_for(int r, bit alt);
    if (r == 0) return 2'b00;
    if (r == 2) return 2'b10;
    return alt ? 2'b11 : 2'b01;
  endfunction

  function automatic logic exp_bit(int s, int p, int d, int n, logic [1:0] h, logic [1:0] l);
    int c, k, half;
    c = 3 * rank(h) + rank(l);
    half = n / 2;
    if (s >= 2 && c == 0) return (d % 2) == 0;
    if (s == 2 && c == 8) return (d % 4) < 2;
    if (s == 3 && c == 8) return p >= half;
    k = (s < 2) ? (c - 4) : (2 * c - 8);
    return ((p - k + 2 * n) % n) < half;
  endfunction

  function automatic string req_of(int s, int c);
    if (s < 2) return "R4 R2";
    if (c == 0) return "R6";
    if (c == 8) return (s == 2) ? "R7" : "R8";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [18:0] v);
    freq_sel = v[18:17];
    for (int s = 0; s < 4; s++) begin
      int c;
      c = int'(v[4*s +: 4]);
      sel_hi[2*s +: 2] = code_for(c / 3, v[16]);
      sel_lo[2*s +: 2] = code_for(c % 3, v[16]);
    end
  endtask

  task automatic clear_mis();
    for (int s = 0; s < 4; s++) mis[s] = 0;
    pmis = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    m_p = 0;
    m_d = 0;
    a_fs = freq_sel;
    a_hi = sel_hi;
    a_lo = sel_lo;
    m_n = n_of(a_fs);
    clear_mis();
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    for (int s = 0; s < 4; s++) begin
      if (clk_out_a[s] !== exp_bit(s, m_p, m_d, m_n, a_hi[2*s +: 2], a_lo[2*s +: 2]))
        mis[s]++;
      if (clk_out_b[s] !== clk_out_a[s]) pmis++;
    end
    if (m_p == m_n - 1) begin
      m_p = 0;
      m_d++;
      a_fs = freq_sel;
      a_hi = sel_hi;
      a_lo = sel_lo;
      m_n = n_of(a_fs);
    end else begin
      m_p++;
    end
  endtask

  task automatic report(string tag, bit force_tag);
    for (int s = 0; s < 4; s++) begin
      int c;
      c = 3 * rank(a_hi[2*s +: 2]) + rank(a_lo[2*s +: 2]);
      check(mis[s] == 0, force_tag ? tag : req_of(s, c),
            $sformatf("%s section %0d mismatching cycles", tag, s), mis[s], 0);
    end
    check(pmis == 0, "R1", $sformatf("%s pair mismatches", tag), pmis, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    freq_sel = 2'b00;
    sel_hi = 8'h55;
    sel_lo = 8'h55;

    // R10: outputs low throughout reset, then phase 0 on the first edge
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(clk_out_a == 4'h0 && clk_out_b == 4'h0, "R10", "outputs during reset",
          int'({clk_out_a, clk_out_b}), 0);
    do_reset();
    step();
    check(clk_out_a == 4'hF, "R10", "first cycle after reset at phase 0",
          int'(clk_out_a), 15);

    // Table walk: each vector runs five base periods from reset
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      do_reset();
      repeat (5 * m_n) step();
      report($sformatf("vec%0d%s", i, (VECS[i][16] || VECS[i][18:17] == 2'b11) ? " R3" : ""), 1'b0);
    end

    // R9: change everything mid-period; old settings must last to the boundary
    apply({2'b00, 1'b0, 4'd4, 4'd4, 4'd4, 4'd4});
    do_reset();
    repeat (10) step();
    freq_sel = 2'b10;
    sel_hi = 8'hAA;
    sel_lo = 8'hAA;
    repeat (34) step();
    report("R9 before boundary", 1'b1);
    clear_mis();
    repeat (4 * 16) step();
    report("R9 after boundary", 1'b1);

    // R9: reset in the middle of a period reloads all settings at once
    apply({2'b10, 1'b0, 4'd0, 4'd8, 4'd2, 4'd6});
    repeat (5) step();
    do_reset();
    repeat (4 * 16) step();
    report("R10 reload", 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule